// File: doc/BRIEF.md
# Operand Register File with Live Input Overlay

This block is the local register memory of a small processor core. It holds 512 words of 32 bits. Three read ports serve the core: a source-operand port, a destination-operand port and an instruction-fetch port. One write port stores results. Every address is backed by an ordinary RAM word, including the addresses reserved for hardware registers.

The only live hardware register modelled here is an input-pin sample at address 0x1F2. It is a two-flop synchronised copy of a 32-bit external pin bus. Substitution is decided by the port that reads, not by the instruction. On the source port, address 0x1F2 returns the live pin sample. On the destination and fetch ports, the same address returns the RAM word stored underneath it. As a result, an instruction that swaps its two operands sees a different value at 0x1F2.

A small AND-test output combines the two operand values. It exposes a zero flag and a parity flag, so the difference between the ports can be seen in one operation.

Top module: `regfile_overlay`

## Requirements
- R1: The fetch port returns the stored RAM word at every address, including 0x1F2, and never the pin sample.
- R2: The source port at address 0x1F2 returns the synchronised pin sample instead of the RAM word.
- R3: The destination port at address 0x1F2 returns the RAM word stored at 0x1F2, not the pin sample.
- R4: A write to 0x1F2 changes only the RAM word there; the source port at 0x1F2 keeps returning the pin sample.
- R5: A change on the pin bus first appears on the source port at 0x1F2 after the second rising clock edge following the change.
- R6: A read of an address written in the same cycle returns the old word; the new word is readable from the cycle after the write edge.
- R7: Every address other than 0x1F2, including the rest of the window 0x1F0 to 0x1FF, returns the RAM word on all three ports.
- R8: The AND-test output equals source AND destination; the zero flag is 1 exactly when that result is 0; the parity flag is the XOR of all 32 result bits.
- R9: While reset is low, all RAM words and the pin sample read as zero and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_in | input | 32 | External input pin bus, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Write address |
| wr_data | input | 32 | Write data |
| src_addr | input | 9 | Source-operand read address |
| dst_addr | input | 9 | Destination-operand read address |
| fetch_addr | input | 9 | Instruction-fetch read address |
| src_data | output | 32 | Source-operand value, overlay applied |
| dst_data | output | 32 | Destination-operand value, RAM only |
| fetch_data | output | 32 | Fetched instruction word, RAM only |
| and_result | output | 32 | src_data AND dst_data |
| and_zero | output | 1 | 1 when and_result is zero |
| and_parity | output | 1 | XOR of all bits of and_result |

## Verification
The hard case is a state where the shadow word at 0x1F2 and the live pin sample both hold known, different values. Only then does a wrong port mapping show up. The stimulus first drives a pin pattern and waits out the synchroniser. It then writes a different pattern to 0x1F2 and reads that address on all three ports at once. Next it runs the AND test with the operands in both orders, so the two results and their flags must differ. A second pin pattern, applied after the shadow write, confirms that the write left the live path untouched.

// File: rtl/regfile_overlay.sv
module regfile_overlay #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] PIN_ADDR = 9'h1F2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pins_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] dst_data,
  output logic [DATA_W-1:0] fetch_data,
  output logic [DATA_W-1:0] and_result,
  output logic              and_zero,
  output logic              and_parity
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] sync_q [SYNC_STAGES];
  logic [DATA_W-1:0] live_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pins_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign live_in = sync_q[SYNC_STAGES-1];

  // The source port has its own substitution; the other ports read the RAM only.
  assign src_data   = (src_addr == PIN_ADDR) ? live_in : mem[src_addr];
  assign dst_data   = mem[dst_addr];
  assign fetch_data = mem[fetch_addr];

  assign and_result = src_data & dst_data;
  assign and_zero   = (and_result == '0);
  assign and_parity = ^and_result;
endmodule

// File: rtl/regfile_overlay_chk.sv
module regfile_overlay_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] PIN_ADDR = 9'h1F2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] pins_in,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [DATA_W-1:0] src_data,
  input logic [DATA_W-1:0] dst_data,
  input logic [DATA_W-1:0] fetch_data,
  input logic              and_zero,
  input logic              and_parity
);
  p_fetch_eq_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr == src_addr && src_addr != PIN_ADDR) |-> fetch_data == src_data);

  p_src_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_addr == PIN_ADDR && $past(rst_n) && $past(rst_n, 2)) |-> src_data == $past(pins_in, 2));

  p_dst_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_addr == fetch_addr) |-> dst_data == fetch_data);

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && fetch_addr == $past(wr_addr)) |-> fetch_data == $past(wr_data));

  p_zero_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    and_zero |-> !and_parity);
endmodule

bind regfile_overlay regfile_overlay_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_ADDR(PIN_ADDR)
) i_chk (
  .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .src_addr(src_addr), .dst_addr(dst_addr), .fetch_addr(fetch_addr),
  .src_data(src_data), .dst_data(dst_data), .fetch_data(fetch_data),
  .and_zero(and_zero), .and_parity(and_parity)
);

// File: tb/test_regfile_overlay.sv
module test_regfile_overlay;
  localparam logic [8:0] PIN = 9'h1F2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins_in = '0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0, src_addr = '0, dst_addr = '0, fetch_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] src_data, dst_data, fetch_data, and_result;
  logic        and_zero, and_parity;

  regfile_overlay i_regfile_overlay (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_addr(src_addr), .dst_addr(dst_addr), .fetch_addr(fetch_addr),
    .src_data(src_data), .dst_data(dst_data), .fetch_data(fetch_data),
    .and_result(and_result), .and_zero(and_zero), .and_parity(and_parity)
  );

  always #2 clk = ~clk;

  typedef struct {
    string       req;
    string       what;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t       q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  bit          want_rst = 1'b0;
  logic [31:0] mem_m [512];
  logic [31:0] p1 = '0, p2 = '0;

  task automatic push(input string req, input string what, input int sel, input logic [31:0] exp);
    item_t it;
    it.req = req; it.what = what; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic cycle(input logic [31:0] pv, input bit we, input logic [8:0] wa,
                       input logic [31:0] wd, input logic [8:0] sa, input logic [8:0] da,
                       input logic [8:0] fa, input string tag);
    logic [31:0] sv, dv, fv, av;
    @(negedge clk);
    rst_n = want_rst; pins_in = pv; wr_en = we; wr_addr = wa; wr_data = wd;
    src_addr = sa; dst_addr = da; fetch_addr = fa;
    sv = (sa == PIN) ? p2 : mem_m[sa];
    dv = mem_m[da];
    fv = mem_m[fa];
    av = sv & dv;
    push(tag, "src", 0, sv);
    push(tag, "dst", 1, dv);
    push(tag, "fetch", 2, fv);
    push(tag, "and", 3, av);
    push(tag, "zero", 4, {31'b0, av == 32'b0});
    push(tag, "parity", 5, {31'b0, ^av});
    if (rst_n) begin
      if (we) mem_m[wa] = wd;
      p2 = p1; p1 = pv;
    end else begin
      p1 = '0; p2 = '0;
    end
  endtask

  always begin
    item_t it;
    logic [31:0] act;
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      it = q.pop_front();
      case (it.sel)
        0: act = src_data;
        1: act = dst_data;
        2: act = fetch_data;
        3: act = and_result;
        4: act = {31'b0, and_zero};
        default: act = {31'b0, and_parity};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s: actual %h expected %h", it.req, it.what, act, it.exp);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem_m[i] = '0;
    // R9: reset holds everything at zero, writes ignored
    want_rst = 1'b0;
    cycle(32'hA5A5A5A5, 1'b1, PIN, 32'h0BAD0BAD, PIN, PIN, PIN, "R9");
    cycle(32'hA5A5A5A5, 1'b1, 9'h005, 32'h77777777, PIN, 9'h005, 9'h005, "R9");
    want_rst = 1'b1;
    cycle(32'hA5A5A5A5, 1'b0, '0, '0, 9'h005, 9'h005, PIN, "R9");
    // R5: latency of the pin synchroniser
    cycle(32'hDEADBEEF, 1'b0, '0, '0, PIN, 9'h000, 9'h000, "R5");
    cycle(32'hDEADBEEF, 1'b0, '0, '0, PIN, 9'h000, 9'h000, "R5");
    cycle(32'hDEADBEEF, 1'b0, '0, '0, PIN, 9'h000, 9'h000, "R5");
    // R4: shadow write at the pin address
    cycle(32'hDEADBEEF, 1'b1, PIN, 32'h12345678, PIN, PIN, PIN, "R4");
    cycle(32'hDEADBEEF, 1'b0, '0, '0, PIN, PIN, PIN, "R4");
    cycle(32'hDEADBEEF, 1'b0, '0, '0, PIN, 9'h000, 9'h000, "R2");
    cycle(32'hDEADBEEF, 1'b0, '0, '0, 9'h000, PIN, 9'h000, "R3");
    cycle(32'hDEADBEEF, 1'b0, '0, '0, 9'h000, 9'h000, PIN, "R1");
    // R2: a second pin pattern after the shadow write
    cycle(32'h0F0F00FF, 1'b0, '0, '0, PIN, PIN, PIN, "R2");
    cycle(32'h0F0F00FF, 1'b0, '0, '0, PIN, PIN, PIN, "R2");
    cycle(32'h0F0F00FF, 1'b0, '0, '0, PIN, PIN, PIN, "R4");
    // R8: AND test with the operands in both orders
    cycle(32'h0F0F00FF, 1'b1, 9'h040, 32'hF0F0F0F1, 9'h000, 9'h000, 9'h000, "R8");
    cycle(32'h0F0F00FF, 1'b1, 9'h041, 32'h00000000, PIN, 9'h040, 9'h040, "R8");
    cycle(32'h0F0F00FF, 1'b0, '0, '0, 9'h040, PIN, 9'h040, "R8");
    cycle(32'h0F0F00FF, 1'b0, '0, '0, PIN, 9'h041, 9'h041, "R8");
    cycle(32'h0F0F00FF, 1'b0, '0, '0, PIN, PIN, 9'h000, "R8");
    // R6: read during write returns the old word
    cycle(32'h0F0F00FF, 1'b1, 9'h010, 32'h11112222, 9'h010, 9'h010, 9'h010, "R6");
    cycle(32'h0F0F00FF, 1'b1, 9'h010, 32'h33334444, 9'h010, 9'h010, 9'h010, "R6");
    cycle(32'h0F0F00FF, 1'b0, '0, '0, 9'h010, 9'h010, 9'h010, "R6");
    // R7: rest of the special window and an ordinary word
    cycle(32'h0F0F00FF, 1'b1, 9'h1F0, 32'hAAAA0001, 9'h000, 9'h000, 9'h000, "R7");
    cycle(32'h0F0F00FF, 1'b1, 9'h1F1, 32'hAAAA0002, 9'h1F0, 9'h1F0, 9'h1F0, "R7");
    cycle(32'h0F0F00FF, 1'b1, 9'h1F3, 32'hAAAA0003, 9'h1F1, 9'h1F1, 9'h1F1, "R7");
    cycle(32'h0F0F00FF, 1'b1, 9'h1FF, 32'hAAAA0004, 9'h1F3, 9'h1F3, 9'h1F3, "R7");
    cycle(32'h0F0F00FF, 1'b0, '0, '0, 9'h1FF, 9'h1FF, 9'h1FF, "R7");
    cycle(32'h0F0F00FF, 1'b0, '0, '0, 9'h041, 9'h010, 9'h1F0, "R7");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule